// File: doc/BRIEF.md
# Signed Integer to Binary Floating-Point Converter

This block turns a signed two's-complement integer into an IEEE-754 binary floating-point number. The source is either 32 or 64 bits wide, and the destination is either single precision (32-bit) or double precision (64-bit). All four combinations run through one datapath. That datapath takes the absolute value, searches for the leading one in two 32-bit halves, left-justifies the magnitude and then packs and rounds the result.

A conversion starts when `start` is high at a clock edge. The packed result, a `done` pulse and any inexact trap indication are registered at that same edge, so they appear one cycle after the request. When the discarded bits are nonzero, the inexact event goes one of two ways. If the trap is enabled, it is reported as a one-cycle exception. Otherwise it sets a sticky status flag, and that flag stays set until a synchronous clear.

Top module: `int2fp_conv`

## Requirements
- R1: A source whose selected bits are all zero gives positive zero (all result bits 0), and no inexact is reported in either the exception or the flag.
- R2: A negative source sets the sign bit and converts the magnitude. The most negative value of each width converts to magnitude 2^31 or 2^63: 0xCF000000 / 0xC1E0000000000000 for a 32-bit source, and 0xDF000000 / 0xC3E0000000000000 for a 64-bit source.
- R3: The result fields depend on the format. Single precision uses sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0, and result bits 63:32 are zero. Double precision uses sign bit 63, exponent bits 62:52 with bias 1023 and fraction bits 51:0. The exponent field equals the bit position of the leading one of the magnitude plus the bias.
- R4: When `src_wide` is 0, only `src[31:0]` is the signed source and `src[63:32]` is ignored. When it is 1, all 64 bits are the source. `dst_dbl` = 1 selects double precision and 0 selects single.
- R5: `rnd_mode` is encoded as 00 nearest with ties to even, 01 toward zero (truncate), 10 toward +infinity and 11 toward -infinity.
- R6: Round toward +infinity adds one to the packed magnitude only for a positive inexact result. Round toward -infinity adds one only for a negative inexact result.
- R7: The rounding increment applies to the concatenated exponent and fraction. A fraction carry-out therefore raises the exponent by one and leaves a zero fraction (for example, 2^32-1 to single precision with nearest rounding gives 0x4F800000).
- R8: With `trap_en` = 1, an inexact conversion raises `inexact_exc` for one cycle, together with `done`, and delivers the rounded result. The sticky flag is not changed.
- R9: With `trap_en` = 0, an inexact conversion sets `inexact_flag`. The flag stays set through later exact conversions and is cleared by `flag_clr`. A set in the same cycle as a clear wins.
- R10: A 32-bit source converted to double precision is always exact and never reports inexact.
- R11: `done` is high exactly one cycle after each `start`. `result` holds its value when there is no `start`. Reset clears `result`, `done`, `inexact_exc` and `inexact_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Convert the current inputs |
| src | input | 64 | Signed source integer |
| src_wide | input | 1 | 1: 64-bit source, 0: 32-bit source in bits 31:0 |
| dst_dbl | input | 1 | 1: double precision result, 0: single |
| rnd_mode | input | 2 | Rounding mode, encoding per R5 |
| trap_en | input | 1 | Report inexact as an exception instead of the sticky flag |
| flag_clr | input | 1 | Synchronous clear of the sticky inexact flag |
| result | output | 64 | Packed result; single precision in bits 31:0 |
| done | output | 1 | One-cycle pulse, result valid |
| inexact_exc | output | 1 | Inexact trap indication, aligned with done |
| inexact_flag | output | 1 | Sticky inexact status |

## Verification
The hardest case to reach is the exact halfway tie. Ties to even only show up when the round bit is one, every lower bit is zero, and the fraction LSB has a chosen value. Random integers almost never produce that pattern. The stimulus therefore builds 2^24+1 and 2^24+3 directly, which tie with even and odd LSBs under single precision, and it also uses 2^32-1 to force the fraction carry into the exponent. A reference model then covers random values and powers of two in every mode and size combination.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;
  localparam int SRC_W   = 64;
  localparam int HALF_W  = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int SP_BIAS = 127;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int DP_BIAS = 1023;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/int2fp_magnitude.sv
// Sign extraction and absolute value. A narrow source is placed in the
// upper half so the normalizer sees one layout for both widths.
module int2fp_magnitude #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] src,
  input  logic         wide,
  output logic         neg,
  output logic [W-1:0] mag
);
  logic [HW-1:0] lo_abs;
  logic [W-1:0]  wide_abs;

  always_comb begin
    lo_abs   = src[HW-1] ? (~src[HW-1:0] + 1'b1) : src[HW-1:0];
    wide_abs = src[W-1]  ? (~src + 1'b1) : src;
    if (wide) begin
      neg = src[W-1];
      mag = wide_abs;
    end else begin
      neg = src[HW-1];
      mag = {lo_abs, {(W-HW){1'b0}}};
    end
  end
endmodule

// File: rtl/int2fp_lzc.sv
// Leading-zero count of one word; W when the word is zero.
module int2fp_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++)
      if (d[i]) cnt = CW'(W - 1 - i);
  end
  assign all_zero = ~|d;
endmodule

// File: rtl/int2fp_normalize.sv
// Shared normalizer: search the upper half first, fall back to the
// lower half plus a half-word offset, then left-justify.
module int2fp_normalize #(
  parameter int W  = 64,
  parameter int HW = 32,
  localparam int LZW = $clog2(W) + 1,
  localparam int HCW = $clog2(HW) + 1
) (
  input  logic [W-1:0]   mag,
  output logic [W-1:0]   norm,
  output logic [LZW-1:0] lz,
  output logic           is_zero
);
  logic [HCW-1:0] cnt_hi, cnt_lo;
  logic           zero_hi, zero_lo;

  int2fp_lzc #(.W(HW)) u_lzc_hi (.d(mag[W-1:W-HW]), .cnt(cnt_hi), .all_zero(zero_hi));
  int2fp_lzc #(.W(HW)) u_lzc_lo (.d(mag[W-HW-1:0]), .cnt(cnt_lo), .all_zero(zero_lo));

  always_comb begin
    lz      = zero_hi ? (LZW'(HW) + LZW'(cnt_lo)) : LZW'(cnt_hi);
    norm    = mag << lz[LZW-2:0];
    is_zero = zero_hi & zero_lo;
  end
endmodule

// File: rtl/int2fp_round.sv
// Pack and round for one destination format. frac_src holds the bits
// below the hidden one, most significant first.
module int2fp_round
  import int2fp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BIAS   = 127,
  parameter int W      = 63,
  parameter int PW     = 7,
  localparam int GB    = W - 1 - FRAC_W
) (
  input  logic [W-1:0]          frac_src,
  input  logic [PW-1:0]         lead_pos,
  input  logic                  neg,
  input  logic [1:0]            mode,
  output logic [EXP_W+FRAC_W:0] packed_res,
  output logic                  inexact
);
  logic [FRAC_W-1:0]       frac;
  logic [EXP_W-1:0]        exp_b;
  logic                    guard, sticky, inc;
  logic [EXP_W+FRAC_W-1:0] field;

  always_comb begin
    frac    = frac_src[W-1 -: FRAC_W];
    guard   = frac_src[GB];
    sticky  = |frac_src[GB-1:0];
    inexact = guard | sticky;
    exp_b   = EXP_W'(BIAS) + EXP_W'(lead_pos);
    case (rnd_mode_e'(mode))
      RM_NEAR: inc = guard & (sticky | frac[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = inexact & ~neg;
      default: inc = inexact & neg;
    endcase
    field      = {exp_b, frac} + {{(EXP_W+FRAC_W-1){1'b0}}, inc};
    packed_res = {neg, field};
  end
endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv
  import int2fp_pkg::*;
#(
  parameter int W  = SRC_W,
  parameter int HW = HALF_W,
  localparam int LZW = $clog2(W) + 1,
  localparam int SPW = 1 + SP_EXP + SP_FRAC,
  localparam int DPW = 1 + DP_EXP + DP_FRAC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] src,
  input  logic         src_wide,
  input  logic         dst_dbl,
  input  logic [1:0]   rnd_mode,
  input  logic         trap_en,
  input  logic         flag_clr,
  output logic [W-1:0] result,
  output logic         done,
  output logic         inexact_exc,
  output logic         inexact_flag
);
  logic           neg;
  logic [W-1:0]   mag, norm;
  logic [LZW-1:0] lz, lead_pos;
  logic           is_zero;
  logic [SPW-1:0] sp_res;
  logic [DPW-1:0] dp_res;
  logic           sp_inx, dp_inx;
  logic [W-1:0]   res_c;
  logic           inx_c;

  int2fp_magnitude #(.W(W), .HW(HW)) u_mag (
    .src(src), .wide(src_wide), .neg(neg), .mag(mag));

  int2fp_normalize #(.W(W), .HW(HW)) u_norm (
    .mag(mag), .norm(norm), .lz(lz), .is_zero(is_zero));

  assign lead_pos = (src_wide ? LZW'(W - 1) : LZW'(HW - 1)) - lz;

  int2fp_round #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC), .BIAS(SP_BIAS), .W(W-1), .PW(LZW)) u_rnd_sp (
    .frac_src(norm[W-2:0]), .lead_pos(lead_pos), .neg(neg), .mode(rnd_mode),
    .packed_res(sp_res), .inexact(sp_inx));

  int2fp_round #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC), .BIAS(DP_BIAS), .W(W-1), .PW(LZW)) u_rnd_dp (
    .frac_src(norm[W-2:0]), .lead_pos(lead_pos), .neg(neg), .mode(rnd_mode),
    .packed_res(dp_res), .inexact(dp_inx));

  always_comb begin
    if (is_zero) begin
      res_c = '0;
      inx_c = 1'b0;
    end else if (dst_dbl) begin
      res_c = W'(dp_res);
      inx_c = dp_inx;
    end else begin
      res_c = W'(sp_res);
      inx_c = sp_inx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      done         <= 1'b0;
      inexact_exc  <= 1'b0;
      inexact_flag <= 1'b0;
    end else begin
      done        <= start;
      inexact_exc <= start & inx_c & trap_en;
      if (start) result <= res_c;
      if (start & inx_c & ~trap_en) inexact_flag <= 1'b1;
      else if (flag_clr)            inexact_flag <= 1'b0;
    end
  end

  // Port-level views used by the checks below
  logic zero_in, sign_in;
  assign zero_in = src_wide ? (src == '0) : (src[HW-1:0] == '0);
  assign sign_in = src_wide ? src[W-1] : src[HW-1];

  assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
    start && zero_in |=> (result == '0) && !inexact_exc);

  assert_sign_R2: assert property (@(posedge clk) disable iff (rst)
    start && !zero_in |=> (($past(dst_dbl) ? result[W-1] : result[SPW-1]) == $past(sign_in)));

  assert_norm_R3: assert property (@(posedge clk) disable iff (rst)
    start && !zero_in |-> norm[W-1]);

  assert_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    start && !dst_dbl |=> (result[W-1:SPW] == '0));

  assert_exc_R8: assert property (@(posedge clk) disable iff (rst)
    inexact_exc |-> done && $past(trap_en));

  assert_trap_noflag_R8: assert property (@(posedge clk) disable iff (rst)
    start && trap_en && !inexact_flag |=> !inexact_flag);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    inexact_flag && !flag_clr |=> inexact_flag);

  assert_exact_R10: assert property (@(posedge clk) disable iff (rst)
    start && !src_wide && dst_dbl |=> !inexact_exc);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result) && !done);
endmodule

// File: tb/int2fp_conv_bench.sv
`timescale 1ns/1ps
module int2fp_conv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] src = '0;
  logic        src_wide = 1'b0, dst_dbl = 1'b0, trap_en = 1'b0, flag_clr = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic [63:0] result;
  logic        done, inexact_exc, inexact_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  int2fp_conv u_int2fp_conv (
    .clk(clk), .rst(rst), .start(start), .src(src), .src_wide(src_wide),
    .dst_dbl(dst_dbl), .rnd_mode(rnd_mode), .trap_en(trap_en), .flag_clr(flag_clr),
    .result(result), .done(done), .inexact_exc(inexact_exc), .inexact_flag(inexact_flag));

  // Independent model: returns {inexact, packed result}
  function automatic logic [64:0] ref_conv(logic [63:0] s, bit wide, bit dbl, logic [1:0] m);
    logic [63:0] v, mag, kept, rem, half, fld, res;
    bit neg, inx, inc;
    int p, f, b, sh;
    v   = wide ? s : {{32{s[31]}}, s[31:0]};
    neg = v[63];
    mag = neg ? (~v + 64'd1) : v;
    if (mag == 0) return 65'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    f = dbl ? 52 : 23;
    b = dbl ? 1023 : 127;
    if (p <= f) begin
      kept = mag << (f - p); rem = 0; half = 1;
    end else begin
      sh = p - f;
      kept = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
    end
    inx = (rem != 0);
    case (m)
      2'b00: inc = (rem > half) || (rem == half && kept[0]);
      2'b01: inc = 0;
      2'b10: inc = inx && !neg;
      default: inc = inx && neg;
    endcase
    fld = (64'(p + b) << f) | (kept & ((64'd1 << f) - 64'd1));
    fld = fld + 64'(inc);
    res = dbl ? {neg, fld[62:0]} : {32'd0, neg, fld[30:0]};
    return {inx, res};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] s, bit w, bit d, logic [1:0] m, bit te, bit clr);
    @(negedge clk);
    src = s; src_wide = w; dst_dbl = d; rnd_mode = m; trap_en = te; flag_clr = clr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset status", {61'd0, done, inexact_exc, inexact_flag}, 64'd0);
  endtask

  task automatic t_zero;
    apply(64'd0, 1, 1, 2'b10, 0, 0);
    chk("R1 zero wide dbl", result, 64'd0);
    chk("R1 zero no inexact", {62'd0, inexact_exc, inexact_flag}, 64'd0);
    apply(64'hDEAD_BEEF_0000_0000, 0, 0, 2'b00, 1, 0);
    chk("R4 R1 narrow ignores upper", result, 64'd0);
    chk("R1 zero exc", {63'd0, inexact_exc}, 64'd0);
  endtask

  task automatic t_extremes;
    apply(64'h0000_0000_8000_0000, 0, 0, 2'b00, 1, 0);
    chk("R2 min32 single", result, 64'h0000_0000_CF00_0000);
    apply(64'h0000_0000_8000_0000, 0, 1, 2'b00, 1, 0);
    chk("R2 min32 double", result, 64'hC1E0_0000_0000_0000);
    apply(64'h8000_0000_0000_0000, 1, 0, 2'b00, 1, 0);
    chk("R2 min64 single", result, 64'h0000_0000_DF00_0000);
    apply(64'h8000_0000_0000_0000, 1, 1, 2'b00, 1, 0);
    chk("R2 min64 double", result, 64'hC3E0_0000_0000_0000);
    apply(64'd1, 1, 0, 2'b00, 1, 0);
    chk("R3 one single", result, 64'h0000_0000_3F80_0000);
    apply(64'd1, 1, 1, 2'b00, 1, 0);
    chk("R3 one double", result, 64'h3FF0_0000_0000_0000);
    apply(64'h1234_5678_FFFF_FFFF, 0, 0, 2'b00, 1, 0);
    chk("R4 R2 narrow minus one", result, 64'h0000_0000_BF80_0000);
    for (int k = 0; k < 64; k++) begin
      apply(64'd1 << k, 1, k[0], 2'b00, 1, 0);
      chk("R3 power of two", result, ref_conv(64'd1 << k, 1, k[0], 2'b00) & {1'b0, {64{1'b1}}});
    end
  endtask

  task automatic t_ties;
    apply(64'd16777217, 1, 0, 2'b00, 1, 0);
    chk("R5 tie even stays", result, 64'h0000_0000_4B80_0000);
    chk("R5 tie inexact", {63'd0, inexact_exc}, 64'd1);
    apply(64'd16777219, 1, 0, 2'b00, 1, 0);
    chk("R5 tie odd rounds up", result, 64'h0000_0000_4B80_0002);
    apply(64'd16777217, 1, 0, 2'b01, 1, 0);
    chk("R5 toward zero", result, 64'h0000_0000_4B80_0000);
  endtask

  task automatic t_directed;
    apply(64'd16777217, 1, 0, 2'b10, 1, 0);
    chk("R6 up positive", result, 64'h0000_0000_4B80_0001);
    apply(64'd16777217, 1, 0, 2'b11, 1, 0);
    chk("R6 down positive", result, 64'h0000_0000_4B80_0000);
    apply(-64'sd16777217, 1, 0, 2'b11, 1, 0);
    chk("R6 down negative", result, 64'h0000_0000_CB80_0001);
    apply(-64'sd16777217, 1, 0, 2'b10, 1, 0);
    chk("R6 up negative", result, 64'h0000_0000_CB80_0000);
  endtask

  task automatic t_carry;
    apply(64'h0000_0000_FFFF_FFFF, 1, 0, 2'b00, 1, 0);
    chk("R7 carry into exponent", result, 64'h0000_0000_4F80_0000);
    apply(64'hFFFF_FFFF_FFFF_FFFF >> 1, 1, 1, 2'b00, 1, 0);
    chk("R7 carry double", result, 64'h43E0_0000_0000_0000);
  endtask

  task automatic t_trap_flag;
    apply(64'd16777217, 1, 0, 2'b00, 1, 0);
    chk("R8 trap raises exc", {63'd0, inexact_exc}, 64'd1);
    chk("R8 trap leaves flag", {63'd0, inexact_flag}, 64'd0);
    @(negedge clk);
    chk("R8 exc one cycle", {63'd0, inexact_exc}, 64'd0);
    apply(64'd16777217, 1, 0, 2'b00, 0, 0);
    chk("R9 flag set", {62'd0, inexact_exc, inexact_flag}, 64'd1);
    apply(64'd5, 1, 0, 2'b00, 0, 0);
    chk("R9 flag sticky", {63'd0, inexact_flag}, 64'd1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 flag cleared", {63'd0, inexact_flag}, 64'd0);
    apply(64'd16777217, 1, 0, 2'b00, 0, 1);
    chk("R9 set beats clear", {63'd0, inexact_flag}, 64'd1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_exact32;
    int bad = 0;
    for (int k = 0; k < 100; k++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      apply(s, 0, 1, 2'($urandom), 1, 0);
      if (inexact_exc !== 1'b0) bad++;
      chk("R10 narrow to double value", result, ref_conv(s, 0, 1, 2'b00) & {1'b0, {64{1'b1}}});
    end
    chk("R10 never inexact", 64'(bad), 64'd0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s;
      logic [64:0] e;
      bit w, d;
      logic [1:0] m;
      s = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 2) s = -s;
      w = $urandom % 2; d = $urandom % 2; m = 2'($urandom);
      e = ref_conv(s, w, d, m);
      apply(s, w, d, m, 1, 0);
      chk("R4 R5 random value", result, e[63:0]);
      chk("R5 R8 random inexact", {63'd0, inexact_exc}, {63'd0, e[64]});
    end
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    apply(64'd12345, 1, 1, 2'b00, 1, 0);
    chk("R11 done after start", {63'd0, done}, 64'd1);
    keep = result;
    src = 64'd999;
    @(negedge clk);
    @(negedge clk);
    chk("R11 done low without start", {63'd0, done}, 64'd0);
    chk("R11 result held", result, keep);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_extremes();
    t_ties();
    t_directed();
    t_carry();
    t_trap_flag();
    t_exact32();
    t_random();
    t_hold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule